// File: doc/BRIEF.md
# Serial Command Port with Chained Pass-Through and Register Read-Out

This block is the serial front end of a multi-channel converter's register bank. An external host drives three wires: an active-low frame select, a serial clock that idles high, and a data line. The block samples all three with its own faster system clock, shifts command bits in on the falling clock edges, and hands each complete 24-bit word to the register bank as a one-cycle strobe once the frame select is released.

The serial output is enabled only while the frame select is low. It presents the word held from the previous frame, most significant bit first, and changes after each rising serial clock so that a downstream receiver can sample on the falling edge. When no read was requested, the word held is the last command received. Chained devices therefore see each command again, 24 clocks later, in longer frames. A command whose top nibble is the read code makes the block fetch one register from the bank. The following frame then shifts out that register's contents, framed by the request's command and address nibbles, while the host sends a no-operation word.

Frames whose clock count is zero or not a whole multiple of 24 are thrown away. Such a frame changes neither the bank nor the word held for the next frame.

Top module: `spid_core`

## Requirements
- R1: While reset is high and after it falls, the output enable, the frame strobe and the read request are low, and the frame output reads zero.
- R2: The serial output enable rises a few system clocks after the frame select falls and drops a few system clocks after it rises.
- R3: Bits are captured on falling serial clock edges, first bit in bit 23. A frame of exactly 24 clocks is presented on `frame_o` with a single-cycle `frame_vld_o` pulse after the frame select rises.
- R4: A frame whose clock count is zero or not a multiple of 24 produces no strobe and no read request. The word shifted out in the next frame is the same as it would have been without the dropped frame.
- R5: In a 48-clock frame, the first 24 output bits are the held word and the next 24 repeat the first 24 input bits of that frame. The last 24 input bits become the committed command.
- R6: The serial output holds its value across each falling serial clock edge and changes only after a rising edge or the frame select falling.
- R7: A committed word whose bits 23:20 equal 1001 raises `rd_req_o` with `rd_addr_o` set to bits 19:16. The bank answers on `rd_data_i` one cycle after the request.
- R8: After a committed word that is not a read, the next frame shifts that same word out, bit 23 first.
- R9: `frame_vld_o` and `rd_req_o` last one system cycle each, and a read request only appears together with its frame strobe.
- R10: The read-out word is the read command nibble in bits 23:20, the address in bits 19:16 and the 16 register bits below. It stays held across aborted frames until a valid frame replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk_i | input | 1 | Serial clock, idles high |
| spi_csn_i | input | 1 | Active-low frame select |
| spi_mosi_i | input | 1 | Serial data in |
| spi_sdo_o | output | 1 | Serial data out |
| spi_sdo_oe_o | output | 1 | Output enable for the serial data out pad |
| frame_o | output | 24 | Last committed command word |
| frame_vld_o | output | 1 | One-cycle strobe when a frame is committed |
| rd_req_o | output | 1 | One-cycle register read request |
| rd_addr_o | output | 4 | Register address for the read request |
| rd_data_i | input | 16 | Register contents, valid one cycle after the request |

## Verification
Within a single serial clock period, the block shifts a new bit into the same register whose top bit it is shifting out. The sharpest case is the frame after a read: the NOP enters while the fetched register leaves. The scoreboard queues the expected output bit for every clock from the bench's own model of the held word. The monitor pops and compares these at each falling edge and also checks that the bit does not move while the clock stays low. Aborted frames placed between a read and its NOP then prove that the held read-out word survives intact.

// File: rtl/spid_pkg.sv
package spid_pkg;
  // Synchronised pin bundle; order fixes the reset vector layout.
  typedef struct packed {
    logic csn;
    logic sclk;
    logic mosi;
  } spid_pins_t;

  localparam spid_pins_t SPID_PINS_IDLE = '{csn: 1'b1, sclk: 1'b1, mosi: 1'b0};
endpackage

// File: rtl/spid_sync.sv
module spid_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spid_bitcnt.sv
module spid_bitcnt #(
  parameter int FRAME_W = 24,
  localparam int CNT_W  = $clog2(FRAME_W)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic step_i,
  output logic whole_o
);
  logic [CNT_W-1:0] cnt;
  logic             full;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (step_i) begin
      if (cnt == CNT_W'(FRAME_W - 1)) begin
        cnt  <= '0;
        full <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign whole_o = full && (cnt == '0);
endmodule

// File: rtl/spid_core.sv
module spid_core #(
  parameter int FRAME_W     = 24,
  parameter int CMD_W       = 4,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [CMD_W-1:0] RB_CMD = 4'h9,
  localparam int DATA_W = FRAME_W - CMD_W - ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               spi_sclk_i,
  input  logic               spi_csn_i,
  input  logic               spi_mosi_i,
  output logic               spi_sdo_o,
  output logic               spi_sdo_oe_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_vld_o,
  output logic               rd_req_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic [DATA_W-1:0]  rd_data_i
);
  import spid_pkg::*;

  localparam int PW     = $bits(spid_pins_t);
  localparam int MSB    = FRAME_W - 1;
  localparam int HDR_W  = CMD_W + ADDR_W;

  spid_pins_t    raw, syn;
  logic [PW-1:0] syn_vec;

  assign raw = '{csn: spi_csn_i, sclk: spi_sclk_i, mosi: spi_mosi_i};

  spid_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(SPID_PINS_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw),
    .dout(syn_vec)
  );
  assign syn = spid_pins_t'(syn_vec);

  // Edge pulses from the synchronised levels.
  logic csn_d, sclk_d;
  logic csn_fall, csn_rise, sclk_fall, sclk_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_d  <= 1'b1;
      sclk_d <= 1'b1;
    end else begin
      csn_d  <= syn.csn;
      sclk_d <= syn.sclk;
    end
  end

  assign csn_fall  =  csn_d & ~syn.csn;
  assign csn_rise  = ~csn_d &  syn.csn;
  assign sclk_fall =  sclk_d & ~syn.sclk & ~syn.csn;
  assign sclk_rise = ~sclk_d &  syn.sclk & ~syn.csn;

  logic whole;

  spid_bitcnt #(.FRAME_W(FRAME_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (csn_fall),
    .step_i (sclk_fall),
    .whole_o(whole)
  );

  // tx: shift register used for capture and chained output.
  // hold: word shifted out at the start of the next frame.
  logic [MSB:0] tx, hold;
  logic         rb_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx           <= '0;
      hold         <= '0;
      spi_sdo_o    <= 1'b0;
      spi_sdo_oe_o <= 1'b0;
      frame_o      <= '0;
      frame_vld_o  <= 1'b0;
      rd_req_o     <= 1'b0;
      rd_addr_o    <= '0;
      rb_cap       <= 1'b0;
    end else begin
      frame_vld_o <= 1'b0;
      rd_req_o    <= 1'b0;
      rb_cap      <= rd_req_o;

      if (rb_cap)
        hold <= {frame_o[MSB -: HDR_W], rd_data_i};

      if (csn_fall) begin
        tx           <= hold;
        spi_sdo_o    <= hold[MSB];
        spi_sdo_oe_o <= 1'b1;
      end else if (sclk_fall) begin
        tx <= {tx[MSB-1:0], syn.mosi};
      end else if (sclk_rise) begin
        spi_sdo_o <= tx[MSB];
      end

      if (csn_rise) begin
        spi_sdo_oe_o <= 1'b0;
        if (whole) begin
          frame_o     <= tx;
          frame_vld_o <= 1'b1;
          hold        <= tx;
          if (tx[MSB -: CMD_W] == RB_CMD) begin
            rd_req_o  <= 1'b1;
            rd_addr_o <= tx[MSB-CMD_W -: ADDR_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/spid_chk.sv
module spid_chk #(
  parameter int FRAME_W = 24,
  parameter int CMD_W   = 4,
  parameter int ADDR_W  = 4,
  parameter logic [CMD_W-1:0] RB_CMD = 4'h9
) (
  input logic               clk,
  input logic               rst,
  input logic               csn_fall,
  input logic               csn_rise,
  input logic               sclk_fall,
  input logic               sclk_rise,
  input logic               sdo,
  input logic               oe,
  input logic               vld,
  input logic [FRAME_W-1:0] frame,
  input logic               rdreq,
  input logic [ADDR_W-1:0]  rdaddr
);
  localparam int CW = $clog2(FRAME_W);

  // Independent count of clocks in the current frame.
  logic [CW-1:0] c_cnt;
  logic          c_full;

  always_ff @(posedge clk) begin
    if (rst || csn_fall) begin
      c_cnt  <= '0;
      c_full <= 1'b0;
    end else if (sclk_fall) begin
      if (c_cnt == CW'(FRAME_W - 1)) begin
        c_cnt  <= '0;
        c_full <= 1'b1;
      end else begin
        c_cnt <= c_cnt + 1'b1;
      end
    end
  end

  p_oe_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(csn_fall));

  p_oe_stop_r2: assert property (@(posedge clk) disable iff (rst)
    csn_rise |=> !oe);

  p_vld_after_release_r3: assert property (@(posedge clk) disable iff (rst)
    vld |-> $past(csn_rise));

  p_drop_partial_r4: assert property (@(posedge clk) disable iff (rst)
    (csn_rise && !(c_full && c_cnt == '0)) |=> (!vld && !rdreq));

  p_sdo_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!sclk_rise && !csn_fall) |=> $stable(sdo));

  p_rdreq_fields_r7: assert property (@(posedge clk) disable iff (rst)
    rdreq |-> (frame[FRAME_W-1 -: CMD_W] == RB_CMD &&
               rdaddr == frame[FRAME_W-1-CMD_W -: ADDR_W]));

  p_vld_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    vld |=> !vld);

  p_rdreq_with_vld_r9: assert property (@(posedge clk) disable iff (rst)
    rdreq |-> vld);
endmodule

bind spid_core spid_chk #(
  .FRAME_W(FRAME_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .RB_CMD(RB_CMD)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .csn_fall (csn_fall),
  .csn_rise (csn_rise),
  .sclk_fall(sclk_fall),
  .sclk_rise(sclk_rise),
  .sdo      (spi_sdo_o),
  .oe       (spi_sdo_oe_o),
  .vld      (frame_vld_o),
  .frame    (frame_o),
  .rdreq    (rd_req_o),
  .rdaddr   (rd_addr_o)
);

// File: tb/spid_core_bench.sv
`timescale 1ns/1ps
module spid_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b1, csn = 1'b1, mosi = 1'b0;
  logic        sdo, sdo_oe, vld, rd_req;
  logic [23:0] frame;
  logic [3:0]  rd_addr;
  logic [15:0] rd_data = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  spid_core u_spid_core (
    .clk(clk), .rst(rst),
    .spi_sclk_i(sclk), .spi_csn_i(csn), .spi_mosi_i(mosi),
    .spi_sdo_o(sdo), .spi_sdo_oe_o(sdo_oe),
    .frame_o(frame), .frame_vld_o(vld),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  function automatic logic [15:0] bank_val(input logic [3:0] a);
    return {4{a}} ^ 16'h1357;
  endfunction

  // Registered register bank model.
  always @(posedge clk) if (rd_req) rd_data <= bank_val(rd_addr);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard queues.
  logic        q_bit[$];
  string       q_tag[$];
  logic [23:0] q_frame[$];
  logic [3:0]  q_addr[$];
  logic [23:0] model_hold = '0;

  // Monitor: serial output at each falling serial clock.
  always @(negedge sclk) begin
    if (!csn) begin
      if (q_bit.size() == 0) check("R5 unexpected sdo bit", 1, 0);
      else check(q_tag.pop_front(), {31'd0, sdo}, {31'd0, q_bit.pop_front()});
    end
  end

  // Monitor: strobes toward the register bank.
  always @(negedge clk) begin
    if (!rst && vld) begin
      if (q_frame.size() == 0) check("R4 unexpected frame strobe", 1, 0);
      else check("R3 frame word", frame, q_frame.pop_front());
    end
    if (!rst && rd_req) begin
      check("R9 read request with strobe", vld, 1);
      if (q_addr.size() == 0) check("R7 unexpected read request", 1, 0);
      else check("R7 read address", rd_addr, q_addr.pop_front());
    end
  end

  task automatic send(input int n, input logic [47:0] w, input string tag);
    logic [23:0] last;
    logic        v;
    last = w[23:0];
    for (int i = 0; i < n; i++) begin
      q_bit.push_back(i < 24 ? model_hold[23-i] : w[n-1-(i-24)]);
      q_tag.push_back(tag);
    end
    if (n > 0 && n % 24 == 0) begin
      q_frame.push_back(last);
      if (last[23:20] == 4'h9) begin
        q_addr.push_back(last[19:16]);
        model_hold = {last[23:16], bank_val(last[19:16])};
      end else begin
        model_hold = last;
      end
    end
    @(negedge clk) csn = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 enable while selected", sdo_oe, 1);
    for (int i = 0; i < n; i++) begin
      mosi = w[n-1-i];
      repeat (4) @(negedge clk);
      v = sdo;
      sclk = 1'b0;
      repeat (8) @(negedge clk);
      check("R6 sdo held while clock low", sdo, v);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    csn = 1'b1;
    repeat (12) @(negedge clk);
    check("R2 disabled after release", sdo_oe, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset oe", sdo_oe, 0);
    check("R1 reset strobe", vld, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 after reset oe", sdo_oe, 0);
    check("R1 after reset frame", frame, 0);
    check("R1 after reset request", rd_req, 0);

    send(24, 48'h312345, "R3 first frame out zero");
    send(24, 48'h2ABCDE, "R8 echo of previous");
    send(10, 48'h3FF,    "R4 aborted ten");
    send(0,  48'h0,      "R4 aborted empty");
    send(24, 48'h000000, "R4 held word unchanged");
    send(24, 48'h950000, "R8 echo before read");
    send(24, 48'h000000, "R7 read-out during nop");
    send(24, 48'h9C1111, "R7 second read");
    send(30, 48'h2AAAAAAA, "R10 read-out across abort");
    send(24, 48'h000000, "R10 read-out kept");
    send(48, 48'hABCDEF_123456, "R5 chained frame");
    send(48, 48'h777777_930000, "R5 chained read");
    send(24, 48'h000000, "R7 read after chain");

    repeat (20) @(negedge clk);
    check("R3 pending frames", q_frame.size(), 0);
    check("R7 pending reads", q_addr.size(), 0);
    check("R5 pending sdo bits", q_bit.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule